// File: doc/BRIEF.md
# Start-Stop Framed Serializer

This block turns a parallel payload word into a single serial bit stream that carries its own timing. Every frame on the line opens with a high start bit and closes with a low stop bit, with the payload in between. A stop bit is always followed at once by the next start bit, so the line shows a low-to-high transition at the same point in every frame. A receiver can lock onto that edge whatever the payload contains, and no separate clock lane or line coding is needed.

The block runs on the bit-rate clock. A payload is presented together with a one-cycle strobe and captured into a holding register. Each new frame takes the most recently captured payload. If no new strobe arrives before a frame ends, the same payload is sent again. The line stays low after reset until the first payload has been strobed in. The payload width is a parameter, and it need not be a multiple of eight.

Top module: `ssf_serializer`

## Requirements
- R1: After reset the line output is 0, and it stays 0 in every cycle until a strobe has been sampled.
- R2: The first start bit (1) is on the line in the cycle that follows the cycle in which the first strobe is sampled. The line is still 0 in that cycle of sampling.
- R3: A frame is PAYLOAD_W+2 consecutive line cycles: slot 0 is the start bit 1; slots 1 to PAYLOAD_W carry payload bits 0 to PAYLOAD_W-1, least significant bit first; slot PAYLOAD_W+1 is the stop bit 0.
- R4: Frames follow each other with no gap, so every frame boundary is a stop 0 followed directly by a start 1, which is a rising edge.
- R5: A frame that begins with no strobe sampled since the previous frame began resends the previous payload unchanged.
- R6: A frame carries the last payload strobed before the clock edge that launches its start bit. When several strobes fall in one frame, the last one wins. A strobe sampled on the very edge that launches a start bit is used by the frame after that one.
- R7: The width is set by PAYLOAD_W and is not restricted to multiples of eight. A 10-bit configuration produces 12-bit frames under the same rules.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Bit-rate clock; one line bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| word_strobe | input | 1 | Captures word_in at this clock edge |
| word_in | input | PAYLOAD_W | Parallel payload word |
| line_out | output | 1 | Serial line with embedded start/stop bits |

## Verification
A strobe that is sampled at an edge moves into the holding register at that edge. The line output is registered, so the start bit of an idle block appears one cycle later. After that, each frame slot occupies exactly one cycle, and the bench expects frames back to back at a fixed period of PAYLOAD_W+2 cycles. The bench drives inputs and samples the line on falling edges. It records every frame slot by slot and compares the whole frame word at once, which makes an off-by-one slot show up as a mismatch. The strobe tests are placed in exact slots: the start slot, the payload slots and the stop slot. This tests the rule about which frame takes a payload at the edge where a strobe and a frame launch coincide.

// File: rtl/ssf_pkg.sv
// Package ssf_pkg
// Holds the shared line levels and the slot classification used by the
// start-stop framed serializer. Assumes frames are start + payload + stop.
package ssf_pkg;

    // Level of the opening framing bit
    localparam logic START_LEVEL = 1'b1;
    // Level of the closing framing bit
    localparam logic STOP_LEVEL  = 1'b0;
    // Level driven while no frame has begun
    localparam logic IDLE_LEVEL  = 1'b0;

    // Kind of bit that the next clock edge will place on the line
    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'd0,
        SLOT_START = 2'd1,
        SLOT_DATA  = 2'd2,
        SLOT_STOP  = 2'd3
    } slot_kind_e;

    // Number of line bits in one frame for a payload width
    function automatic int frame_bits(input int payload_w);
        return payload_w + 2;
    endfunction

endpackage

// File: rtl/ssf_in_latch.sv
// Module ssf_in_latch
// Input holding register. It captures the payload on each strobe and
// raises a sticky flag once any payload has been captured since reset.
// Assumes the strobe is synchronous to the bit clock.
module ssf_in_latch #(
    parameter int PAYLOAD_W = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 strobe_i,
    input  logic [PAYLOAD_W-1:0] word_i,
    output logic [PAYLOAD_W-1:0] hold_o,
    output logic                 primed_o
);

    logic [PAYLOAD_W-1:0] hold_q;
    logic                 primed_q;

    // Capture the payload and note that one has arrived
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q   <= '0;
            primed_q <= 1'b0;
        end else if (strobe_i) begin
            hold_q   <= word_i;
            primed_q <= 1'b1;
        end
    end

    assign hold_o   = hold_q;
    assign primed_o = primed_q;

endmodule

// File: rtl/ssf_sequencer.sv
// Module ssf_sequencer
// Frame slot sequencer. It stays idle until the latch is primed and then
// steps through PAYLOAD_W+2 slots per frame, wrapping with no gap. It
// reports what the next edge must put on the line.
// Assumes primed_i never falls once it has risen (it only clears on reset).
module ssf_sequencer
    import ssf_pkg::*;
#(
    parameter int PAYLOAD_W = 18
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       primed_i,
    output slot_kind_e next_kind_o
);

    localparam int          FRAME_LEN = frame_bits(PAYLOAD_W);
    localparam int          CW        = $clog2(FRAME_LEN);
    localparam logic [CW-1:0] LAST_SLOT = CW'(FRAME_LEN - 1);
    localparam logic [CW-1:0] LAST_DATA = CW'(PAYLOAD_W);

    logic          active_q;
    logic [CW-1:0] slot_q;
    logic          launch;

    // A frame launches from idle once primed, or after every stop slot
    always_comb begin
        launch = (!active_q && primed_i) || (active_q && (slot_q == LAST_SLOT));
    end

    // Advance the slot that is now on the line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            slot_q   <= '0;
        end else if (launch) begin
            active_q <= 1'b1;
            slot_q   <= '0;
        end else if (active_q) begin
            slot_q   <= slot_q + CW'(1);
        end
    end

    // Classify the slot that the coming edge will drive
    always_comb begin
        if (launch) begin
            next_kind_o = SLOT_START;
        end else if (!active_q) begin
            next_kind_o = SLOT_IDLE;
        end else if (slot_q < LAST_DATA) begin
            next_kind_o = SLOT_DATA;
        end else begin
            next_kind_o = SLOT_STOP;
        end
    end

endmodule

// File: rtl/ssf_shifter.sv
// Module ssf_shifter
// Frame shifter and line register. At a start slot it copies the held
// payload into its shift register. It then sends the payload LSB first and
// ends with the stop level. The line output is a flop.
// Assumes next_kind_i describes the slot the coming edge launches.
module ssf_shifter
    import ssf_pkg::*;
#(
    parameter int PAYLOAD_W = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  slot_kind_e           next_kind_i,
    input  logic [PAYLOAD_W-1:0] hold_i,
    output logic                 line_o
);

    logic [PAYLOAD_W-1:0] shift_q;
    logic                 line_q;

    // Drive the line bit for the next slot and move the payload along
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            line_q  <= IDLE_LEVEL;
        end else begin
            case (next_kind_i)
                SLOT_START: begin
                    line_q  <= START_LEVEL;
                    shift_q <= hold_i;
                end
                SLOT_DATA: begin
                    line_q  <= shift_q[0];
                    shift_q <= shift_q >> 1;
                end
                SLOT_STOP: begin
                    line_q  <= STOP_LEVEL;
                end
                default: begin
                    line_q  <= IDLE_LEVEL;
                end
            endcase
        end
    end

    assign line_o = line_q;

endmodule

// File: rtl/ssf_serializer.sv
// Module ssf_serializer (top)
// Start-stop framed serializer. A payload is captured on a strobe and sent
// as frames of start 1, PAYLOAD_W payload bits LSB first and stop 0, back
// to back. The last payload is repeated until a new one is strobed in.
// Assumes a single bit-rate clock and a synchronous active-low reset.
module ssf_serializer
    import ssf_pkg::*;
#(
    parameter int PAYLOAD_W = 18
) (
    input  logic                 bit_clk,
    input  logic                 rst_n,
    input  logic                 word_strobe,
    input  logic [PAYLOAD_W-1:0] word_in,
    output logic                 line_out
);

    logic [PAYLOAD_W-1:0] latch_hold;
    logic                 latch_primed;
    slot_kind_e           seq_kind;

    // Payload capture
    ssf_in_latch #(.PAYLOAD_W(PAYLOAD_W)) u_latch (
        .clk      (bit_clk),
        .rst_n    (rst_n),
        .strobe_i (word_strobe),
        .word_i   (word_in),
        .hold_o   (latch_hold),
        .primed_o (latch_primed)
    );

    // Slot sequencing
    ssf_sequencer #(.PAYLOAD_W(PAYLOAD_W)) u_seq (
        .clk         (bit_clk),
        .rst_n       (rst_n),
        .primed_i    (latch_primed),
        .next_kind_o (seq_kind)
    );

    // Line shifting
    ssf_shifter #(.PAYLOAD_W(PAYLOAD_W)) u_shift (
        .clk         (bit_clk),
        .rst_n       (rst_n),
        .next_kind_i (seq_kind),
        .hold_i      (latch_hold),
        .line_o      (line_out)
    );

endmodule

// File: rtl/ssf_serializer_chk.sv
// Module ssf_serializer_chk
// Checker for the framed serializer. It keeps its own frame phase counter,
// which starts in the cycle after the latch is primed, and checks the
// framing levels against that phase. Bound to every ssf_serializer.
module ssf_serializer_chk #(
    parameter int PAYLOAD_W = 18
) (
    input logic clk,
    input logic rst_n,
    input logic primed,
    input logic line
);

    localparam int            FRAME_LEN = PAYLOAD_W + 2;
    localparam int            CW        = $clog2(FRAME_LEN);
    localparam logic [CW-1:0] LAST      = CW'(FRAME_LEN - 1);

    logic          run_q;
    logic [CW-1:0] phase_q;

    // Independent frame phase: 0 is the start slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            phase_q <= '0;
        end else if (!run_q && primed) begin
            run_q   <= 1'b1;
            phase_q <= '0;
        end else if (run_q) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + CW'(1);
        end
    end

    // R1: line low until framing starts
    a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> !line);

    // R2: start bit follows priming by one cycle
    a_r2_first_start: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !run_q) |=> line);

    // R3: start slot is high
    a_r3_start_high: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && phase_q == '0) |-> line);

    // R3: stop slot is low
    a_r3_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && phase_q == LAST) |-> !line);

    // R4: every start bit is a rising edge
    a_r4_rising_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && phase_q == '0) |-> $rose(line));

endmodule

bind ssf_serializer ssf_serializer_chk #(.PAYLOAD_W(PAYLOAD_W)) u_chk (
    .clk    (bit_clk),
    .rst_n  (rst_n),
    .primed (latch_primed),
    .line   (line_out)
);

// File: tb/sim_ssf_serializer.sv
// Directed bench for ssf_serializer: an 18-bit instance u0 and a 10-bit
// instance u1. Inputs are driven and the line is sampled on falling edges.
module sim_ssf_serializer;

    localparam int W   = 18;
    localparam int FL  = W + 2;
    localparam int W10 = 10;
    localparam int FL10 = W10 + 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           strobe = 1'b0;
    logic [W-1:0]   word = '0;
    logic           line;
    logic           strobe10 = 1'b0;
    logic [W10-1:0] word10 = '0;
    logic           line10;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    ssf_serializer #(.PAYLOAD_W(W)) u0 (
        .bit_clk(clk), .rst_n(rst_n), .word_strobe(strobe),
        .word_in(word), .line_out(line)
    );

    ssf_serializer #(.PAYLOAD_W(W10)) u1 (
        .bit_clk(clk), .rst_n(rst_n), .word_strobe(strobe10),
        .word_in(word10), .line_out(line10)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Record one frame slot by slot, optionally strobing in two slots
    task automatic run_frame(input logic [W-1:0] exp,
                             input int s1, input logic [W-1:0] v1,
                             input int s2, input logic [W-1:0] v2,
                             input string tag, output logic [FL-1:0] got);
        logic [FL-1:0] want;
        for (int s = 0; s < FL; s++) begin
            @(negedge clk);
            got[s] = line;
            if (s == s1) begin
                strobe = 1'b1; word = v1;
            end else if (s == s2) begin
                strobe = 1'b1; word = v2;
            end else begin
                strobe = 1'b0;
            end
        end
        want = {1'b0, exp, 1'b1};
        check(got == want, tag, 64'(got), 64'(want));
    endtask

    logic [FL-1:0] fa, fb;
    logic [W-1:0]  cur;

    task automatic t_reset();
        bit low = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) begin
            @(negedge clk);
            if (line !== 1'b0) low = 1'b0;
        end
        check(low, "R1 idle low after reset", 64'(line), 64'd0);
    endtask

    task automatic t_first();
        cur = 18'h2C3A5;
        @(negedge clk); strobe = 1'b1; word = cur;
        @(negedge clk);
        check(line === 1'b0, "R2 line low in strobe cycle", 64'(line), 64'd0);
        strobe = 1'b0;
        run_frame(cur, -1, '0, -1, '0, "R2 R3 first frame", fa);
    endtask

    task automatic t_repeat();
        run_frame(cur, -1, '0, -1, '0, "R5 payload resent", fb);
        check({fa[FL-1], fb[0]} == 2'b01, "R4 boundary rising edge",
              64'({fa[FL-1], fb[0]}), 64'd1);
    endtask

    task automatic t_midload();
        run_frame(cur, 5, 18'h1B0F3, -1, '0, "R6 frame before mid strobe", fa);
        cur = 18'h1B0F3;
        run_frame(cur, -1, '0, -1, '0, "R6 mid-frame strobe used", fa);
    endtask

    task automatic t_lastwins();
        run_frame(cur, 2, 18'h0F0F0, 10, 18'h33CC3, "R6 frame with two strobes", fa);
        cur = 18'h33CC3;
        run_frame(cur, -1, '0, -1, '0, "R6 last strobe wins", fa);
    endtask

    task automatic t_stopslot();
        run_frame(cur, FL - 1, 18'h2468A, -1, '0, "R6 strobe in stop slot", fa);
        run_frame(cur, -1, '0, -1, '0, "R6 stop-edge strobe deferred", fa);
        cur = 18'h2468A;
        run_frame(cur, -1, '0, -1, '0, "R6 deferred payload sent", fa);
    endtask

    task automatic t_startslot();
        run_frame(cur, 0, 18'h13579, -1, '0, "R6 strobe in start slot", fa);
        cur = 18'h13579;
        run_frame(cur, -1, '0, -1, '0, "R6 start-slot strobe next frame", fa);
    endtask

    task automatic t_patterns();
        logic [W-1:0] pats [4];
        pats[0] = '1; pats[1] = '0; pats[2] = 18'h2AAAA; pats[3] = 18'h15555;
        for (int i = 0; i < 4; i++) begin
            run_frame(cur, 7, pats[i], -1, '0, "R3 pattern lead-in", fa);
            cur = pats[i];
            run_frame(cur, -1, '0, -1, '0, "R3 R4 data pattern", fb);
            check({fa[FL-1], fb[0]} == 2'b01, "R4 pattern boundary",
                  64'({fa[FL-1], fb[0]}), 64'd1);
        end
    endtask

    task automatic t_width10();
        logic [FL10-1:0] g;
        logic [FL10-1:0] want;
        logic [W10-1:0]  v = 10'h2D6;
        want = {1'b0, v, 1'b1};
        @(negedge clk); strobe10 = 1'b1; word10 = v;
        @(negedge clk); strobe10 = 1'b0;
        for (int f = 0; f < 2; f++) begin
            for (int s = 0; s < FL10; s++) begin
                @(negedge clk);
                g[s] = line10;
            end
            check(g == want, "R7 10-bit frame", 64'(g), 64'(want));
        end
    endtask

    initial begin
        t_reset();
        t_width10();
        t_first();
        t_repeat();
        t_midload();
        t_lastwins();
        t_stopslot();
        t_startslot();
        t_patterns();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule